// File: doc/BRIEF.md
# AHB to APB bridge

This block connects a single-layer AHB-Lite system bus to a peripheral bus built on the APB protocol. On the AHB side it is one slave. On the APB side it is the only requester. When an AHB transfer is accepted, the bridge stores the address and the direction. For a write it also stores the write data, which arrives one cycle later. It then decodes the stored address into one of `NSLV` peripheral selects and runs a two-phase APB access. The AHB data phase is held with `hreadyout` low until the APB side finishes. The bridge then returns the read data with an OKAY response, or a two-cycle ERROR response.

Peripheral windows are `2**WIN_BITS` bytes each and are packed from `REGION` upwards. Address bits [13:12] select the peripheral and bits [31:14] must equal those of `REGION`. An address outside every window is refused with ERROR, and no APB access starts. Bursts are handled as a series of single transfers, and both buses run on `hclk`.

The state machine has seven states:
- IDLE: nothing pending.
- WCAP: write-data capture.
- SETUP and ACCESS: the two APB phases.
- DONE: OKAY completion.
- ERR1 and ERR2: the two cycles of an ERROR response.

The transitions are as follows:
- IDLE, DONE and ERR2 all accept a new transfer. A mapped write goes to WCAP, a mapped read goes to SETUP, and an unmapped address goes to ERR1. With no transfer they go to IDLE.
- WCAP goes to SETUP, and SETUP goes to ACCESS.
- ACCESS stays put while `pready` is low. When `pready` is high it goes to DONE, or to ERR1 if `pslverr` is high.
- ERR1 goes to ERR2.

Top module: `ahb_pbridge`

## Requirements
- R1: Out of reset, `hreadyout` is 1, `hresp` is 0 (OKAY), `psel` is all zero and `penable` is 0.
- R2: A cycle with `hready` high that is not a selected NONSEQ (`htrans`=2'b10) or SEQ (2'b11) transfer starts no APB access and is answered in the next cycle with `hreadyout` 1 and `hresp` 0. Inputs presented while `hready` is low are ignored.
- R3: For an address with bits [31:14] equal to those of `REGION` and bits [13:12] = k < NSLV, exactly bit k of `psel` is raised. `paddr` equals the AHB address and `pwrite` equals `hwrite`.
- R4: Every APB access has exactly one SETUP cycle (`psel` set, `penable` 0) followed by ACCESS (`penable` 1). A read enters SETUP in the cycle after its address phase. A write first spends one cycle capturing `hwdata`, and `pwdata` carries that value.
- R5: ACCESS lasts while `pready` is low. Throughout ACCESS, `paddr`, `pwrite`, `pwdata`, `psel` and `penable` stay unchanged.
- R6: `hreadyout` stays low from the cycle after acceptance until completion. A successful transfer with w wait states completes in data-phase cycle 3+w for a read and 4+w for a write.
- R7: A successful read returns on `hrdata`, in its final data-phase cycle, the `prdata` value sampled when `pready` was high.
- R8: If `pslverr` is high in the ACCESS cycle where `pready` is high, for a read or a write, the response is ERROR. The first cycle has `hresp` 1 with `hreadyout` 0 and the second has `hresp` 1 with `hreadyout` 1. Its total latency is one cycle more than the OKAY case. `pslverr` at any other time has no effect.
- R9: An unmapped address (wrong bits [31:14], or index ≥ NSLV) gets the two-cycle ERROR response in data-phase cycles 1 and 2, and no `psel` bit is ever raised for it.
- R10: A new address phase presented in the final (`hreadyout` high) cycle of a previous transfer, whether OKAY or ERROR, is accepted and served with the same timing as from idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk | input | 1 | Clock for both buses |
| hresetn | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | AHB slave select for the bridge |
| haddr | input | ADDR_W | AHB address |
| htrans | input | 2 | AHB transfer type |
| hwrite | input | 1 | AHB direction, 1 = write |
| hwdata | input | DATA_W | AHB write data (data phase) |
| hready | input | 1 | AHB bus ready, qualifies the address phase |
| hreadyout | output | 1 | Bridge ready towards the AHB side |
| hresp | output | 1 | AHB response, 1 = ERROR |
| hrdata | output | DATA_W | AHB read data |
| paddr | output | ADDR_W | APB address |
| psel | output | NSLV | One-hot APB peripheral selects |
| penable | output | 1 | APB access-phase strobe |
| pwrite | output | 1 | APB direction |
| pwdata | output | DATA_W | APB write data |
| prdata | input | DATA_W | APB read data from the selected peripheral |
| pready | input | 1 | APB completion from the selected peripheral |
| pslverr | input | 1 | APB slave error |

## Verification
Two events share a cycle at the end of every transfer. The response of the ending transfer appears in its last cycle, with `hreadyout` high. The bridge also takes in the next address phase on that same edge, from the DONE or ERR2 state. The bench presents most transfers with no gap, so each new address lands exactly in the final cycle of the previous one. Some of these follow slave-error or unmapped ERROR responses, and others follow OKAY completions. Each transfer is judged on its own: its response code, its read data and its data-phase length are compared with values the bench computes, and an accepted-but-lost or doubly-served transfer shows up as a wrong latency or stray APB activity.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WCAP,
        ST_SETUP,
        ST_ACCESS,
        ST_DONE,
        ST_ERR1,
        ST_ERR2
    } pbr_state_e;

    localparam logic [1:0] HT_IDLE   = 2'b00;
    localparam logic [1:0] HT_BUSY   = 2'b01;
    localparam logic [1:0] HT_NONSEQ = 2'b10;
    localparam logic [1:0] HT_SEQ    = 2'b11;

endpackage

// File: rtl/pbr_decode.sv
module pbr_decode #(
    parameter int                ADDR_W   = 32,
    parameter int                NSLV     = 3,
    parameter int                WIN_BITS = 12,
    parameter logic [ADDR_W-1:0] REGION   = 32'h4000_0000
) (
    input  logic [ADDR_W-1:WIN_BITS] addr_hi,
    output logic                     hit,
    output logic [NSLV-1:0]          sel
);

    localparam int IDX_W   = (NSLV > 1) ? $clog2(NSLV) : 1;
    localparam int TAG_LSB = WIN_BITS + IDX_W;

    logic             tag_ok;
    logic [IDX_W-1:0] idx;

    assign tag_ok = (addr_hi[ADDR_W-1:TAG_LSB] == REGION[ADDR_W-1:TAG_LSB]);
    assign idx    = addr_hi[TAG_LSB-1:WIN_BITS];

    for (genvar i = 0; i < NSLV; i++) begin : g_win
        assign sel[i] = tag_ok && (idx == IDX_W'(i));
    end

    assign hit = |sel;

endmodule

// File: rtl/pbr_fsm.sv
module pbr_fsm
    import pbr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hit,
    input  logic write,
    input  logic pready,
    input  logic pslverr,
    output logic take_addr,
    output logic cap_wdata,
    output logic cap_rdata,
    output logic apb_act,
    output logic penable,
    output logic hreadyout,
    output logic hresp
);

    pbr_state_e state, nxt;
    logic       open_st;

    assign open_st = (state == ST_IDLE) || (state == ST_DONE) || (state == ST_ERR2);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_DONE, ST_ERR2: begin
                if (start) begin
                    if (!hit) begin
                        nxt = ST_ERR1;
                    end else if (write) begin
                        nxt = ST_WCAP;
                    end else begin
                        nxt = ST_SETUP;
                    end
                end else begin
                    nxt = ST_IDLE;
                end
            end
            ST_WCAP:   nxt = ST_SETUP;
            ST_SETUP:  nxt = ST_ACCESS;
            ST_ACCESS: begin
                if (pready) begin
                    nxt = pslverr ? ST_ERR1 : ST_DONE;
                end
            end
            ST_ERR1:   nxt = ST_ERR2;
            default:   nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        hreadyout = open_st;
        hresp     = (state == ST_ERR1) || (state == ST_ERR2);
        apb_act   = (state == ST_SETUP) || (state == ST_ACCESS);
        penable   = (state == ST_ACCESS);
        cap_wdata = (state == ST_WCAP);
        cap_rdata = (state == ST_ACCESS) && pready;
        take_addr = open_st && start;
    end

endmodule

// File: rtl/ahb_pbridge.sv
module ahb_pbridge
    import pbr_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                DATA_W   = 32,
    parameter int                NSLV     = 3,
    parameter int                WIN_BITS = 12,
    parameter logic [ADDR_W-1:0] REGION   = 32'h4000_0000
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              hready,
    output logic              hreadyout,
    output logic              hresp,
    output logic [DATA_W-1:0] hrdata,
    output logic [ADDR_W-1:0] paddr,
    output logic [NSLV-1:0]   psel,
    output logic              penable,
    output logic              pwrite,
    output logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] prdata,
    input  logic              pready,
    input  logic              pslverr
);

    logic              start;
    logic              hit;
    logic [NSLV-1:0]   dec_sel;
    logic              take_addr;
    logic              cap_wdata;
    logic              cap_rdata;
    logic              apb_act;
    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic [NSLV-1:0]   sel_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    assign start = hsel && hready && ((htrans == HT_NONSEQ) || (htrans == HT_SEQ));

    pbr_decode #(
        .ADDR_W   (ADDR_W),
        .NSLV     (NSLV),
        .WIN_BITS (WIN_BITS),
        .REGION   (REGION)
    ) u_decode (
        .addr_hi (haddr[ADDR_W-1:WIN_BITS]),
        .hit     (hit),
        .sel     (dec_sel)
    );

    pbr_fsm u_fsm (
        .clk       (hclk),
        .rst_n     (hresetn),
        .start     (start),
        .hit       (hit),
        .write     (hwrite),
        .pready    (pready),
        .pslverr   (pslverr),
        .take_addr (take_addr),
        .cap_wdata (cap_wdata),
        .cap_rdata (cap_rdata),
        .apb_act   (apb_act),
        .penable   (penable),
        .hreadyout (hreadyout),
        .hresp     (hresp)
    );

    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            addr_q  <= '0;
            write_q <= 1'b0;
            sel_q   <= '0;
        end else if (take_addr) begin
            addr_q  <= haddr;
            write_q <= hwrite;
            sel_q   <= dec_sel;
        end
    end

    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            wdata_q <= '0;
        end else if (cap_wdata) begin
            wdata_q <= hwdata;
        end
    end

    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            rdata_q <= '0;
        end else if (cap_rdata) begin
            rdata_q <= prdata;
        end
    end

    assign paddr  = addr_q;
    assign pwrite = write_q;
    assign pwdata = wdata_q;
    assign psel   = apb_act ? sel_q : '0;
    assign hrdata = rdata_q;

endmodule

// File: rtl/pbr_chk.sv
module pbr_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int NSLV   = 3
) (
    input logic              hclk,
    input logic              hresetn,
    input logic              hsel,
    input logic              hready,
    input logic [1:0]        htrans,
    input logic              hreadyout,
    input logic              hresp,
    input logic [ADDR_W-1:0] paddr,
    input logic [NSLV-1:0]   psel,
    input logic              penable,
    input logic              pwrite,
    input logic [DATA_W-1:0] pwdata,
    input logic              pready
);

    AST_SEL_ONEHOT: assert property (@(posedge hclk) disable iff (!hresetn) $onehot0(psel)); // R3
    AST_SETUP_THEN_ACCESS: assert property (@(posedge hclk) disable iff (!hresetn) (|psel && !penable) |=> (|psel && penable)); // R4
    AST_ENABLE_HAS_SEL: assert property (@(posedge hclk) disable iff (!hresetn) penable |-> |psel); // R4
    AST_ACCESS_HOLD: assert property (@(posedge hclk) disable iff (!hresetn) (penable && !pready) |=> (penable && $stable(psel) && $stable(paddr) && $stable(pwrite) && $stable(pwdata))); // R5
    AST_STALL_WHILE_WAIT: assert property (@(posedge hclk) disable iff (!hresetn) (penable && !pready) |-> !hreadyout); // R6
    AST_ERR_FIRST_HALF: assert property (@(posedge hclk) disable iff (!hresetn) (hresp && !hreadyout) |=> (hresp && hreadyout)); // R8
    AST_ERR_SECOND_HALF: assert property (@(posedge hclk) disable iff (!hresetn) (hresp && hreadyout) |-> $past(hresp && !hreadyout)); // R8
    AST_NO_XFER_OKAY: assert property (@(posedge hclk) disable iff (!hresetn) (hready && hreadyout && !(hsel && htrans[1])) |=> (hreadyout && !hresp && (psel == '0))); // R2

endmodule

bind ahb_pbridge pbr_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NSLV   (NSLV)
) u_chk (
    .hclk      (hclk),
    .hresetn   (hresetn),
    .hsel      (hsel),
    .hready    (hready),
    .htrans    (htrans),
    .hreadyout (hreadyout),
    .hresp     (hresp),
    .paddr     (paddr),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .pwdata    (pwdata),
    .pready    (pready)
);

// File: tb/ahb_pbridge_tb.sv
module ahb_pbridge_tb;

    localparam int NS = 3;
    localparam int NT = 300;

    logic        hclk = 1'b0;
    logic        hresetn;
    logic        hsel;
    logic [31:0] haddr;
    logic [1:0]  htrans;
    logic        hwrite;
    logic [31:0] hwdata;
    logic        hready;
    logic        hreadyout;
    logic        hresp;
    logic [31:0] hrdata;
    logic [31:0] paddr;
    logic [NS-1:0] psel;
    logic        penable;
    logic        pwrite;
    logic [31:0] pwdata;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;

    always #5 hclk = ~hclk;

    assign hready = hreadyout;

    ahb_pbridge u_dut (
        .hclk      (hclk),
        .hresetn   (hresetn),
        .hsel      (hsel),
        .haddr     (haddr),
        .htrans    (htrans),
        .hwrite    (hwrite),
        .hwdata    (hwdata),
        .hready    (hready),
        .hreadyout (hreadyout),
        .hresp     (hresp),
        .hrdata    (hrdata),
        .paddr     (paddr),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .pwdata    (pwdata),
        .prdata    (prdata),
        .pready    (pready),
        .pslverr   (pslverr)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] slv_mem [NS][16];
    logic [31:0] ref_mem [NS][16];

    logic [31:0] t_addr  [NT];
    logic [31:0] t_wdata [NT];
    logic        t_write [NT];
    logic [1:0]  t_trans [NT];
    int          t_waits [NT];
    logic        t_err   [NT];
    int          t_gap   [NT];

    // pending data phase
    logic        p_act = 1'b0;
    int          p_kind;      // 0 no transfer, 1 mapped, 2 unmapped
    logic        p_write;
    logic [31:0] p_addr;
    logic [31:0] p_wdata;
    int          p_waits;
    logic        p_err;
    int          p_idx;
    logic        p_experr;
    int          p_expcyc;
    logic [31:0] p_exprd;
    int          p_cycles;
    logic        p_b2b;
    logic        prev_e1;
    int          wcnt;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit mapped(input logic [31:0] a);
        return (a[31:14] == 18'h10000) && (a[13:12] < 2'd3);
    endfunction

    function automatic logic [31:0] mk_addr(input int idx, input int word);
        return 32'h4000_0000 | (32'(idx) << 12) | (32'(word) << 2);
    endfunction

    function automatic int exp_cycles(input int kind, input logic wr, input int waits, input logic er);
        if (kind == 2) return 2;
        return 3 + waits + (wr ? 1 : 0) + (er ? 1 : 0);
    endfunction

    task automatic set_t(input int i, input logic [1:0] tr, input logic [31:0] a, input logic wr,
                         input logic [31:0] wd, input int w, input logic e, input int g);
        t_trans[i] = tr; t_addr[i] = a; t_write[i] = wr; t_wdata[i] = wd;
        t_waits[i] = w; t_err[i] = e; t_gap[i] = g;
    endtask

    initial begin
        int k;
        int gap_left;
        int cyc;
        bit done;
        bit just_done;
        logic [31:0] seed_v;

        seed_v = $urandom(32'h5EED_0042);
        for (int i = 0; i < NS; i++) begin
            for (int j = 0; j < 16; j++) begin
                slv_mem[i][j] = 32'hA500_0000 | (32'(i) << 8) | 32'(j);
                ref_mem[i][j] = 32'hA500_0000 | (32'(i) << 8) | 32'(j);
            end
        end

        // directed corner cases
        set_t(0, 2'b10, mk_addr(0, 1),  1'b0, 32'h0,          0, 1'b0, 0);
        set_t(1, 2'b10, mk_addr(1, 2),  1'b1, 32'hDEAD_BEEF,  0, 1'b0, 0);
        set_t(2, 2'b11, mk_addr(1, 2),  1'b0, 32'h0,          3, 1'b0, 0);
        set_t(3, 2'b10, mk_addr(3, 0),  1'b1, 32'h1111_2222,  0, 1'b0, 0);
        set_t(4, 2'b10, 32'h5000_1004,  1'b0, 32'h0,          0, 1'b0, 1);
        set_t(5, 2'b10, mk_addr(2, 5),  1'b1, 32'h1234_5678,  2, 1'b1, 0);
        set_t(6, 2'b10, mk_addr(2, 5),  1'b0, 32'h0,          0, 1'b0, 0);
        set_t(7, 2'b10, mk_addr(0, 7),  1'b0, 32'h0,          1, 1'b1, 0);
        set_t(8, 2'b10, mk_addr(2, 15), 1'b1, 32'hCAFE_F00D,  5, 1'b0, 2);
        set_t(9, 2'b11, mk_addr(2, 15), 1'b0, 32'h0,          0, 1'b0, 0);
        for (int i = 10; i < NT; i++) begin
            int r;
            logic [31:0] a;
            r = int'($urandom % 10);
            if (r < 7)      a = mk_addr(int'($urandom % 3), int'($urandom % 16));
            else if (r < 9) a = mk_addr(3, int'($urandom % 16));
            else            a = 32'h5000_0000 | ($urandom & 32'h0000_3FFC);
            set_t(i, ($urandom % 2 == 0) ? 2'b10 : 2'b11, a, $urandom % 2 == 1, $urandom,
                  ($urandom % 3 == 0) ? int'($urandom % 4) : 0,
                  ($urandom % 6 == 0),
                  ($urandom % 4 == 0) ? int'($urandom % 3) : 0);
        end

        // reset
        hresetn = 1'b0; hsel = 1'b0; haddr = '0; htrans = 2'b00; hwrite = 1'b0; hwdata = '0;
        prdata = '0; pready = 1'b0; pslverr = 1'b0;
        repeat (3) @(negedge hclk);
        chk(hreadyout == 1'b1, "R1 hreadyout in reset", 32'(hreadyout), 32'h1);
        chk(hresp == 1'b0,     "R1 hresp in reset",     32'(hresp),     32'h0);
        chk(psel == '0,        "R1 psel in reset",      32'(psel),      32'h0);
        chk(penable == 1'b0,   "R1 penable in reset",   32'(penable),   32'h0);
        hresetn = 1'b1;

        k = 0; gap_left = t_gap[0]; cyc = 0; done = 1'b0; prev_e1 = 1'b0; wcnt = 0;
        while (!done) begin
            @(negedge hclk);
            cyc++;

            // APB peripheral model
            if (|psel) begin
                chk(p_act && p_kind == 1, "R9/R2 APB select without mapped transfer", 32'(psel), 32'h0);
            end
            if (penable) begin
                int sidx;
                sidx = (psel == 3'b010) ? 1 : (psel == 3'b100) ? 2 : 0;
                if (wcnt == 0) begin
                    chk(psel == 3'(1 << p_idx), "R3 psel", 32'(psel), 32'(1 << p_idx));
                    chk(paddr == p_addr, "R3 paddr", paddr, p_addr);
                    chk(pwrite == p_write, "R3 pwrite", 32'(pwrite), 32'(p_write));
                    if (p_write) chk(pwdata == p_wdata, "R4 pwdata", pwdata, p_wdata);
                end
                if (wcnt >= p_waits) begin
                    pready = 1'b1; pslverr = p_err;
                    prdata = slv_mem[sidx][paddr[5:2]];
                    if (pwrite && !p_err) slv_mem[sidx][paddr[5:2]] = pwdata;
                    wcnt = 0;
                end else begin
                    pready = 1'b0; pslverr = 1'($urandom); prdata = $urandom;
                    wcnt++;
                end
            end else begin
                pready = 1'($urandom); pslverr = 1'($urandom); prdata = $urandom;
            end

            // AHB data phase
            just_done = 1'b0;
            if (p_act) begin
                p_cycles++;
                if (p_write) hwdata = p_wdata; else hwdata = $urandom;
                if (hreadyout) begin
                    string lat_tag;
                    lat_tag = p_b2b ? "R6/R10 latency" : "R6 latency";
                    chk(hresp == p_experr, p_kind == 2 ? "R9 response" : (p_kind == 0 ? "R2 response" : "R8 response"),
                        32'(hresp), 32'(p_experr));
                    chk(p_cycles == p_expcyc, lat_tag, 32'(p_cycles), 32'(p_expcyc));
                    if (p_experr) chk(prev_e1, "R8/R9 first error cycle missing", 32'(prev_e1), 32'h1);
                    if (p_kind == 1 && !p_write && !p_err) chk(hrdata == p_exprd, "R7 hrdata", hrdata, p_exprd);
                    p_act = 1'b0;
                    just_done = (p_kind != 0);
                end else if (p_cycles > 40) begin
                    chk(1'b0, "R6 transfer never completed", 32'(p_cycles), 32'(p_expcyc));
                    done = 1'b1;
                end
            end else begin
                hwdata = $urandom;
            end
            prev_e1 = hresp && !hreadyout;

            // AHB address phase
            if (hreadyout) begin
                if (k >= NT && !p_act) begin
                    hsel = 1'b0; htrans = 2'b00;
                    done = 1'b1;
                end else if (k < NT && gap_left == 0) begin
                    hsel = 1'b1; htrans = t_trans[k]; haddr = t_addr[k]; hwrite = t_write[k];
                    p_act = 1'b1; p_cycles = 0; p_b2b = just_done;
                    p_kind = mapped(t_addr[k]) ? 1 : 2;
                    p_write = t_write[k]; p_addr = t_addr[k]; p_wdata = t_wdata[k];
                    p_waits = t_waits[k]; p_err = (p_kind == 1) && t_err[k];
                    p_idx = int'(t_addr[k][13:12]);
                    p_experr = (p_kind == 2) || p_err;
                    p_expcyc = exp_cycles(p_kind, p_write, p_waits, p_err);
                    p_exprd = (p_kind == 1) ? ref_mem[p_idx][t_addr[k][5:2]] : 32'h0;
                    if (p_kind == 1 && p_write && !p_err) ref_mem[p_idx][t_addr[k][5:2]] = p_wdata;
                    wcnt = 0;
                    k++;
                    if (k < NT) gap_left = t_gap[k];
                end else begin
                    hsel = 1'($urandom);
                    htrans = hsel ? {1'b0, 1'($urandom)} : 2'($urandom);
                    haddr = $urandom; hwrite = 1'($urandom);
                    p_act = 1'b1; p_cycles = 0; p_kind = 0; p_write = 1'b0; p_b2b = 1'b0;
                    p_experr = 1'b0; p_expcyc = 1; p_err = 1'b0; p_waits = 0;
                    if (gap_left > 0) gap_left--;
                end
            end else begin
                // ignored while hready is low (R2)
                hsel = 1'($urandom); htrans = 2'($urandom); haddr = $urandom; hwrite = 1'($urandom);
            end

            if (cyc > 100000) begin
                chk(1'b0, "watchdog expired", 32'(cyc), 32'h0);
                done = 1'b1;
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule